// File: doc/BRIEF.md
# Dual-Bank Reloadable FIR Filter

A single-channel, single-rate direct-form FIR filter with 37 taps. It keeps two independent banks of coefficients. Each accepted input sample is filtered through the bank named by the compute select at the moment of acceptance. The other bank can be rewritten one coefficient per cycle through a write-enable port while the sample stream keeps flowing. Products and their sum are kept at full precision: 16-bit signed samples times 16-bit signed coefficients, summed over 37 taps, give a 38-bit signed result with no rounding.

Both stream sides use valid/ready handshakes. A small output state machine has two states. `ST_EMPTY` means no result is held. `ST_FULL` means a result waits for the consumer. Its transitions are:
- LOAD: `ST_EMPTY` to `ST_FULL` when a sample is taken.
- PASS: `ST_FULL` to `ST_FULL` when the held result leaves and a new sample is taken in the same cycle.
- DRAIN: `ST_FULL` to `ST_EMPTY` when the result leaves and no sample is taken.
- HOLD: `ST_FULL` stays put while the consumer stalls.

Coefficient writes go to a write address that starts at tap 0 and advances by one with each write. The address restarts at tap 0 whenever the reload select changes.

Top module: `fir_dual_bank`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) empties the output (`out_valid` 0, `in_ready` 1). It clears the sample history and every coefficient of both banks to zero, and returns the write address to tap 0 with the remembered reload select at 0.
- R2: For an accepted sample x[n], the output equals the sum over k=0..36 of c[k]·x[n−k] as an exact 38-bit two's-complement value. History samples older than the last reset count as zero.
- R3: The result of a sample accepted at a clock edge is presented with `out_valid` high right after that same edge.
- R4: `calc_sel` is sampled in the accept cycle: 0 selects bank 0 and 1 selects bank 1. Later changes of `calc_sel` do not alter a result already computed.
- R5: Each cycle with `coef_we` high stores `coef_data` (16-bit signed) into bank `load_sel` at the current write address, then advances the address by one. Tap address i is the coefficient multiplying x[n−i].
- R6: The write address wraps from tap 36 back to tap 0, so the 38th consecutive write overwrites tap 0.
- R7: When `load_sel` differs from its value in the previous cycle, the write address returns to tap 0. A write in that same cycle lands on tap 0 of the newly selected bank.
- R8: Writing one bank never changes results computed through the other bank, even when writes and accepts happen in the same cycles. A write takes effect only for samples accepted after its clock edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R10: `in_ready` equals `!out_valid || out_ready`. Every accepted sample yields exactly one result, in order, with none dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 16 | Signed input sample |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Filter can take a sample this cycle |
| calc_sel | input | 1 | Bank used for the sample being accepted |
| load_sel | input | 1 | Bank that receives coefficient writes |
| coef_we | input | 1 | Write one coefficient this cycle |
| coef_data | input | 16 | Signed coefficient value |
| out_data | output | 38 | Full-precision signed filter result |
| out_valid | output | 1 | Result held for the consumer |
| out_ready | input | 1 | Consumer takes the result this cycle |

## Verification
A result is due one clock edge after its sample is accepted. A coefficient write affects only samples accepted after the edge that stores it, and a change of `load_sel` moves the write address to tap 0 in the same cycle.

The bench drives every input on the falling edge. It reads both the handshake and the outputs 2 ns later, which is before the next rising edge. From the values it sees there, it decides which transfers the coming edge performs. It pushes the expected sum of each accept into an ordered queue, using the coefficients as they stand before that edge. It compares each result at the moment it is handed over. Hold and latency checks look at the ports one cycle after the accept.

// File: rtl/fdb_pkg.sv
package fdb_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;

    localparam int BANKS = 2;

endpackage

// File: rtl/fdb_coef_store.sv
module fdb_coef_store #(
    parameter int TAPS   = 37,
    parameter int COEF_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic                           wsel,
    input  logic [COEF_W-1:0]              wdata,
    input  logic                           rsel,
    output logic [TAPS-1:0][COEF_W-1:0]    coef_o
);
    localparam int AW = $clog2(TAPS);

    logic [COEF_W-1:0] mem [fdb_pkg::BANKS][TAPS];
    logic [AW-1:0]     addr_q;
    logic [AW-1:0]     base;
    logic              wsel_q;

    // address restarts whenever the reload target moves
    always_comb begin
        base = (wsel != wsel_q) ? '0 : addr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsel_q <= 1'b0;
            addr_q <= '0;
            for (int b = 0; b < fdb_pkg::BANKS; b++) begin
                for (int t = 0; t < TAPS; t++) begin
                    mem[b][t] <= '0;
                end
            end
        end else begin
            wsel_q <= wsel;
            if (we) begin
                mem[wsel][base] <= wdata;
                addr_q <= (base == AW'(TAPS - 1)) ? '0 : base + 1'b1;
            end else begin
                addr_q <= base;
            end
        end
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_rd
        assign coef_o[k] = mem[rsel][k];
    end

endmodule

// File: rtl/fdb_tap_line.sv
module fdb_tap_line #(
    parameter int TAPS   = 37,
    parameter int DATA_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           shift,
    input  logic [DATA_W-1:0]              din,
    output logic [TAPS-1:0][DATA_W-1:0]    win
);
    localparam int DEPTH = TAPS - 1;

    logic [DATA_W-1:0] line_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                line_q[i] <= '0;
            end
        end else if (shift) begin
            line_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                line_q[i] <= line_q[i-1];
            end
        end
    end

    // window position 0 is the sample arriving now
    for (genvar k = 0; k < TAPS; k++) begin : g_win
        if (k == 0) begin : g_new
            assign win[k] = din;
        end else begin : g_old
            assign win[k] = line_q[k-1];
        end
    end

endmodule

// File: rtl/fdb_mac.sv
module fdb_mac #(
    parameter int TAPS   = 37,
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 38
) (
    input  logic [TAPS-1:0][DATA_W-1:0]    win,
    input  logic [TAPS-1:0][COEF_W-1:0]    coef,
    output logic signed [ACC_W-1:0]        sum
);
    localparam int PW = DATA_W + COEF_W;

    logic signed [PW-1:0] prod [TAPS];

    for (genvar k = 0; k < TAPS; k++) begin : g_mul
        assign prod[k] = $signed(win[k]) * $signed(coef[k]);
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < TAPS; k++) begin
            sum = sum + ACC_W'(prod[k]);
        end
    end

endmodule

// File: rtl/fir_dual_bank.sv
module fir_dual_bank #(
    parameter int TAPS   = 37,
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int OUT_W  = DATA_W + COEF_W + $clog2(TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              calc_sel,
    input  logic              load_sel,
    input  logic              coef_we,
    input  logic [COEF_W-1:0] coef_data,
    output logic [OUT_W-1:0]  out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    import fdb_pkg::*;

    out_state_e                       state_q, state_d;
    logic                             take;
    logic [TAPS-1:0][COEF_W-1:0]      coef_sel;
    logic [TAPS-1:0][DATA_W-1:0]      win;
    logic signed [OUT_W-1:0]          sum;
    logic [OUT_W-1:0]                 res_q;

    assign take = in_valid && in_ready;

    fdb_coef_store #(.TAPS(TAPS), .COEF_W(COEF_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (coef_we),
        .wsel   (load_sel),
        .wdata  (coef_data),
        .rsel   (calc_sel),
        .coef_o (coef_sel)
    );

    fdb_tap_line #(.TAPS(TAPS), .DATA_W(DATA_W)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (take),
        .din   (in_data),
        .win   (win)
    );

    fdb_mac #(.TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(OUT_W)) u_mac (
        .win  (win),
        .coef (coef_sel),
        .sum  (sum)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and handshake outputs
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (take) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !take) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
        in_ready  = (state_q == ST_EMPTY) || out_ready;
        out_valid = (state_q == ST_FULL);
    end

    // result register, loaded only on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (take) begin
            res_q <= sum;
        end
    end

    assign out_data = res_q;

endmodule

// File: rtl/fdb_chk.sv
module fdb_chk #(
    parameter int OUT_W = 38
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [OUT_W-1:0] out_data,
    input logic             out_valid,
    input logic             out_ready
);
    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    p_result_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_stall_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_free_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    p_no_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(out_ready));

endmodule

bind fir_dual_bank fdb_chk #(.OUT_W(OUT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready)
);

// File: tb/fir_dual_bank_tb_top.sv
module fir_dual_bank_tb_top;
    localparam int TAPS = 37;
    localparam int DW   = 16;
    localparam int CW   = 16;
    localparam int OW   = 38;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] in_data;
    logic          in_valid;
    logic          in_ready;
    logic          calc_sel;
    logic          load_sel;
    logic          coef_we;
    logic [CW-1:0] coef_data;
    logic [OW-1:0] out_data;
    logic          out_valid;
    logic          out_ready;

    always #4 clk = ~clk;

    fir_dual_bank dut_i (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .calc_sel(calc_sel), .load_sel(load_sel),
        .coef_we(coef_we), .coef_data(coef_data), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready)
    );

    int    n_run  = 0;
    int    n_fail = 0;
    int    n_acc  = 0;
    int    n_out  = 0;
    string cur    = "R1";

    logic signed [CW-1:0] mcoef [2][TAPS];
    logic signed [DW-1:0] mhist [TAPS];
    int                   maddr;
    logic                 mprev;
    logic signed [OW-1:0] expq [$];

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference model and scoreboard, sampled 2 ns after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst_n) begin
                for (int b = 0; b < 2; b++)
                    for (int t = 0; t < TAPS; t++) mcoef[b][t] = '0;
                for (int t = 0; t < TAPS; t++) mhist[t] = '0;
                maddr = 0;
                mprev = 1'b0;
                expq.delete();
            end else begin
                if (out_valid && out_ready) begin
                    n_out++;
                    if (expq.size() == 0) begin
                        chk(1'b0, "R10", longint'($signed(out_data)), 0);
                    end else begin
                        logic signed [OW-1:0] e;
                        e = expq.pop_front();
                        chk($signed(out_data) == e, cur, longint'($signed(out_data)), longint'(e));
                    end
                end
                if (in_valid && in_ready) begin
                    longint s;
                    for (int t = TAPS - 1; t > 0; t--) mhist[t] = mhist[t-1];
                    mhist[0] = $signed(in_data);
                    s = 0;
                    for (int t = 0; t < TAPS; t++)
                        s += longint'(mhist[t]) * longint'(mcoef[calc_sel][t]);
                    expq.push_back(OW'(s));
                    n_acc++;
                end
                if (coef_we) begin
                    int a;
                    a = (load_sel != mprev) ? 0 : maddr;
                    mcoef[load_sel][a] = $signed(coef_data);
                    maddr = (a == TAPS - 1) ? 0 : a + 1;
                end else if (load_sel != mprev) begin
                    maddr = 0;
                end
                mprev = load_sel;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // ---------------- drivers (all called at a falling edge) ----------------
    task automatic send(logic [DW-1:0] d, logic s);
        bit took;
        in_data  = d;
        calc_sel = s;
        in_valid = 1'b1;
        do begin
            #3 took = in_ready;
            @(negedge clk);
        end while (!took);
        in_valid = 1'b0;
    endtask

    task automatic wr(logic b, logic [CW-1:0] v);
        load_sel  = b;
        coef_we   = 1'b1;
        coef_data = v;
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        out_ready = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (expq.size() == 0 && !out_valid) break;
        end
        #3 chk(expq.size() == 0 && n_acc == n_out, "R10", n_out, n_acc);
        @(negedge clk);
    endtask

    task automatic impulse(logic s);
        send(16'd1, s);
        for (int i = 0; i < TAPS; i++) send(16'd0, s);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        cur = "R1";
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R1", out_valid, 0);
        chk(in_ready == 1'b1, "R1", in_ready, 1);
        @(negedge clk);
        impulse(1'b0);
        impulse(1'b1);
        drain();
    endtask

    task automatic t_order();
        cur = "R5";
        load_sel = 1'b1;
        idle(1);
        for (int i = 0; i < TAPS; i++) wr(1'b0, CW'(i * 100 - 1700));
        impulse(1'b0);
        cur = "R2";
        for (int i = 0; i < 50; i++) send(DW'((i * 2731) ^ 16'h5a3c), 1'b0);
        drain();
    endtask

    task automatic t_latency();
        cur = "R3";
        send(16'd77, 1'b0);
        #1 chk(out_valid == 1'b1, "R3", out_valid, 1);
        drain();
    endtask

    task automatic t_bank_pick();
        bit done = 0;
        cur = "R4";
        for (int i = 0; i < TAPS; i++) wr(1'b1, CW'(((i % 5) - 2) * 1000 + i));
        fork
            begin
                for (int i = 0; i < 60; i++) send(DW'(i * 911 - 20000), ((i * 7) % 3) == 0);
                done = 1;
            end
            begin
                int j = 0;
                while (!done) begin
                    out_ready = (j % 4) != 1;
                    calc_sel  = ~calc_sel;
                    j++;
                    @(negedge clk);
                end
            end
        join
        drain();
    endtask

    task automatic t_wrap();
        cur = "R6";
        load_sel = 1'b0;
        idle(1);
        for (int i = 0; i < TAPS + 3; i++) wr(1'b1, CW'(i * 37 + 5));
        impulse(1'b1);
        drain();
    endtask

    task automatic t_sel_move();
        cur = "R7";
        for (int i = 0; i < 5; i++) wr(1'b0, CW'(-300 - i));
        wr(1'b1, 16'h1234);
        wr(1'b1, 16'h0042);
        wr(1'b0, 16'h7fff);
        wr(1'b0, 16'h8000);
        impulse(1'b0);
        impulse(1'b1);
        drain();
    endtask

    task automatic t_live_reload();
        cur = "R8";
        fork
            for (int i = 0; i < 70; i++) send(DW'(i * 1237 + 3), 1'b0);
            begin
                load_sel = 1'b0;
                @(negedge clk);
                for (int i = 0; i < 60; i++) wr(1'b1, CW'(i * 500 - 15000));
            end
        join
        for (int i = 0; i < 40; i++) send(DW'(i * 321), 1'b1);
        drain();
    endtask

    task automatic t_backpressure();
        logic [OW-1:0] held;
        cur = "R9";
        out_ready = 1'b0;
        send(16'd999, 1'b0);
        #1 held = out_data;
        for (int i = 0; i < 4; i++) begin
            chk(out_valid == 1'b1, "R9", out_valid, 1);
            chk(out_data == held, "R9", longint'($signed(out_data)), longint'($signed(held)));
            chk(in_ready == 1'b0, "R10", in_ready, 0);
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        drain();
    endtask

    task automatic t_extreme();
        cur = "R2";
        load_sel = 1'b1;
        idle(1);
        for (int i = 0; i < TAPS; i++) wr(1'b0, 16'h8000);
        for (int i = 0; i < TAPS; i++) send(16'h8000, 1'b0);
        for (int i = 0; i < TAPS; i++) send(16'h7fff, 1'b0);
        drain();
    endtask

    initial begin
        rst_n     = 1'b0;
        in_data   = '0;
        in_valid  = 1'b0;
        calc_sel  = 1'b0;
        load_sel  = 1'b0;
        coef_we   = 1'b0;
        coef_data = '0;
        out_ready = 1'b1;
        idle(2);
        t_reset();
        t_order();
        t_latency();
        t_bank_pick();
        t_wrap();
        t_sel_move();
        t_live_reload();
        t_backpressure();
        t_extreme();
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule